// File: doc/BRIEF.md
# Dual-Edge-Point PWM Fan Generator

This block drives a set of fan PWM outputs from the system clock. One shared clock setting picks a two-stage prescaler (a power-of-two stage times an even-multiple stage) and a period length in prescaled ticks. Each output has its own enable and a pair of 8-bit counter positions. The output rises when the period counter reaches the rise position and falls when it reaches the fall position. A fall position of zero means the output never falls.

A small state machine sequences the shared counter. `ST_IDLE` holds everything cleared while the global enable is low. `idle_to_load` fires when the global enable is seen high. `ST_LOAD` copies the clock setting and all duty fields into shadow registers and starts count 0 (`load_to_run`). `ST_RUN` advances the count once per prescaled tick. It takes `run_wrap`, which reloads the shadows at the period boundary, and `run_step` otherwise. Dropping the global enable in `ST_LOAD` or `ST_RUN` takes `any_to_idle`. Outputs are pairs of 16-bit duty halves, so two ports share one 32-bit duty word.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is asserted, and after it until the block is enabled, every `pwm_out` bit is 0.
- R2: `ctrl_word[0]` is the global run enable. When it is sampled low, all outputs are 0 after the next clock edge and the period counter restarts from 0 on the next enable.
- R3: The high prescaler code `clk_cfg[7:4]` = H multiplies the tick length by 2^H.
- R4: The low prescaler code `clk_cfg[3:0]` = L multiplies the tick length by 1 when L is 0 and by 2·L otherwise. Each count therefore lasts D = (L==0 ? 1 : 2L)·2^H clock cycles.
- R5: The period is U+1 counts (0..U) with U = `clk_cfg[15:8]`, so the output period is D·(U+1) clock cycles.
- R6: Port p takes its rise position from `duty_bus[16p+7:16p]` and its fall position from `duty_bus[16p+15:16p+8]`. Even port 2k thus uses bits 15:0 and odd port 2k+1 uses bits 31:16 of duty word k.
- R7: On entering count c, the output goes low if the fall position is nonzero and equals c. Otherwise it goes high if the rise position equals c, and otherwise it holds. Equal nonzero positions therefore keep the output low.
- R8: A fall position of 0 never drives the output low. Rise 0 with fall 0 gives 100% duty from the first count.
- R9: `ctrl_word[p+1]` enables port p. When it is low, that output is 0 after the next clock edge.
- R10: Clock setting and duty fields are sampled only when count 0 is entered. A change made mid-period has no effect until the next period.
- R11: With the global enable first sampled high at edge E0, count 0 starts at edge E0+1, and the output for count 0 is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | NUM_PORTS+1 | Bit 0 global enable, bit p+1 enable of port p |
| clk_cfg | input | 2*CODE_W+UNIT_W | Low code [3:0], high code [7:4], period unit [15:8] |
| duty_bus | input | NUM_PORTS*2*UNIT_W | Per-port rise (low byte) and fall (high byte) positions |
| pwm_out | output | NUM_PORTS | Fan PWM outputs |

## Verification
An output reflects the enable sampled at edge E0 only after edge E0+1, where count 0 begins. Each later count lasts D cycles, so the level after edge n belongs to count ((n-1)/D) mod (U+1). The bench numbers the edges from the one that samples the enable. After each edge it samples at the falling clock edge and compares against the level that bench functions compute by stepping through the rise and fall rule. Port or global disables are due after exactly one edge, so they are checked on the first falling edge after the change. A mid-period duty change is checked both in the rest of the old period and in the next one.

// File: rtl/fan_pwm_pkg.sv
`timescale 1ns/1ps
package fan_pwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    // Clock cycles per prescaled tick for a given pair of codes.
    function automatic int unsigned prescale_ratio(input int unsigned lo, input int unsigned hi);
        int unsigned mult;
        mult = (lo == 0) ? 1 : 2 * lo;
        return mult << hi;
    endfunction

endpackage

// File: rtl/fpg_prescaler.sv
`timescale 1ns/1ps
module fpg_prescaler #(
    parameter int CODE_W = 4,
    parameter int PC_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] lo_code,
    input  logic [CODE_W-1:0] hi_code,
    output logic              tick
);

    logic [PC_W-1:0] mult;
    logic [PC_W-1:0] ratio_m1;
    logic [PC_W-1:0] pc_q;

    always_comb begin
        if (lo_code == '0) begin
            mult = PC_W'(1);
        end else begin
            mult = PC_W'({lo_code, 1'b0});
        end
        ratio_m1 = (mult << hi_code) - PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run || (pc_q == ratio_m1)) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    assign tick = run && (pc_q == ratio_m1);

    // R4
    pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pc_q <= ratio_m1));

    // R3
    pc_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc_q == '0));

endmodule

// File: rtl/fpg_sequencer.sv
`timescale 1ns/1ps
module fpg_sequencer
    import fan_pwm_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int UNIT_W = 8,
    parameter int CFG_W  = 2 * CODE_W + UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic              tick,
    output logic              pre_run,
    output logic [CODE_W-1:0] lo_s,
    output logic [CODE_W-1:0] hi_s,
    output logic              advance,
    output logic              bound,
    output logic [UNIT_W-1:0] cnt_nxt,
    output logic              run_ok
);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [CFG_W-1:0]  cfg_s;
    logic [UNIT_W-1:0] cnt_q;
    logic [UNIT_W-1:0] cnt_d;
    logic [UNIT_W-1:0] unit_s;
    logic              wrap;

    assign lo_s   = cfg_s[CODE_W-1:0];
    assign hi_s   = cfg_s[2*CODE_W-1:CODE_W];
    assign unit_s = cfg_s[CFG_W-1:2*CODE_W];
    assign wrap   = (cnt_q == unit_s);

    // Next state and counter decisions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        advance = 1'b0;
        bound   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (glb_en) begin
                    state_d = ST_LOAD;           // idle_to_load
                end
            end
            ST_LOAD: begin
                cnt_d = '0;
                if (!glb_en) begin
                    state_d = ST_IDLE;           // any_to_idle
                end else begin
                    state_d = ST_RUN;            // load_to_run
                    advance = 1'b1;
                    bound   = 1'b1;
                end
            end
            ST_RUN: begin
                if (!glb_en) begin
                    state_d = ST_IDLE;           // any_to_idle
                    cnt_d   = '0;
                end else if (tick) begin
                    advance = 1'b1;
                    if (wrap) begin
                        bound = 1'b1;            // run_wrap
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + UNIT_W'(1); // run_step
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg_s <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (bound) begin
                cfg_s <= cfg_in;
            end
        end
    end

    assign cnt_nxt = cnt_d;
    assign pre_run = (state_q == ST_RUN);
    assign run_ok  = glb_en && (state_q != ST_IDLE);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= unit_s));

    // R2
    glb_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (state_q == ST_IDLE) && (cnt_q == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !(tick && wrap)) |=> $stable(cfg_s));

    // R11
    load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q != ST_LOAD));

endmodule

// File: rtl/fpg_port.sv
`timescale 1ns/1ps
module fpg_port #(
    parameter int UNIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_ok,
    input  logic                en,
    input  logic                advance,
    input  logic                bound,
    input  logic [UNIT_W-1:0]   cnt_nxt,
    input  logic [2*UNIT_W-1:0] duty_in,
    output logic                lvl
);

    logic [UNIT_W-1:0] rise_s;
    logic [UNIT_W-1:0] fall_s;
    logic [UNIT_W-1:0] rise_e;
    logic [UNIT_W-1:0] fall_e;
    logic              fall_hit;
    logic              rise_hit;

    // At a period boundary the fresh fields apply to count 0 directly.
    assign rise_e   = bound ? duty_in[UNIT_W-1:0]        : rise_s;
    assign fall_e   = bound ? duty_in[2*UNIT_W-1:UNIT_W] : fall_s;
    assign fall_hit = (fall_e != '0) && (fall_e == cnt_nxt);
    assign rise_hit = (rise_e == cnt_nxt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_s <= '0;
            fall_s <= '0;
        end else if (bound) begin
            rise_s <= duty_in[UNIT_W-1:0];
            fall_s <= duty_in[2*UNIT_W-1:UNIT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
        end else if (!run_ok || !en) begin
            lvl <= 1'b0;
        end else if (advance) begin
            if (fall_hit) begin
                lvl <= 1'b0;
            end else if (rise_hit) begin
                lvl <= 1'b1;
            end
        end
    end

    // R9
    port_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !lvl);

    // R8
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && en && $past(run_ok && en && lvl && (fall_s == '0) && !bound)) |-> lvl);

endmodule

// File: rtl/fan_pwm_gen.sv
`timescale 1ns/1ps
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CODE_W    = 4,
    parameter int UNIT_W    = 8,
    parameter int CFG_W     = 2 * CODE_W + UNIT_W,
    parameter int DUTY_W    = NUM_PORTS * 2 * UNIT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS:0]   ctrl_word,
    input  logic [CFG_W-1:0]     clk_cfg,
    input  logic [DUTY_W-1:0]    duty_bus,
    output logic [NUM_PORTS-1:0] pwm_out
);

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int PC_W     = $clog2(prescale_ratio(CODE_MAX, CODE_MAX) + 1);
    localparam int HALF_W   = 2 * UNIT_W;

    logic              tick;
    logic              pre_run;
    logic [CODE_W-1:0] lo_s;
    logic [CODE_W-1:0] hi_s;
    logic              advance;
    logic              bound;
    logic [UNIT_W-1:0] cnt_nxt;
    logic              run_ok;

    fpg_sequencer #(
        .CODE_W (CODE_W),
        .UNIT_W (UNIT_W),
        .CFG_W  (CFG_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_en  (ctrl_word[0]),
        .cfg_in  (clk_cfg),
        .tick    (tick),
        .pre_run (pre_run),
        .lo_s    (lo_s),
        .hi_s    (hi_s),
        .advance (advance),
        .bound   (bound),
        .cnt_nxt (cnt_nxt),
        .run_ok  (run_ok)
    );

    fpg_prescaler #(
        .CODE_W (CODE_W),
        .PC_W   (PC_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pre_run),
        .lo_code (lo_s),
        .hi_code (hi_s),
        .tick    (tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fpg_port #(
            .UNIT_W (UNIT_W)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_ok  (run_ok),
            .en      (ctrl_word[p+1]),
            .advance (advance),
            .bound   (bound),
            .cnt_nxt (cnt_nxt),
            .duty_in (duty_bus[p*HALF_W +: HALF_W]),
            .lvl     (pwm_out[p])
        );
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

endmodule

// File: tb/fan_pwm_gen_bench.sv
`timescale 1ns/1ps
module fan_pwm_gen_bench;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP:0]   ctrl_word = '0;
    logic [15:0]   clk_cfg = '0;
    logic [NP*16-1:0] duty_bus = '0;
    logic [NP-1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int t_rise [NP];
    int t_fall [NP];

    always #10 clk = ~clk;

    fan_pwm_gen u_fan_pwm_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .clk_cfg   (clk_cfg),
        .duty_bus  (duty_bus),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Cycles per count, from the two prescaler codes.
    function automatic int ratio(input int lo, input int hi);
        return ((lo == 0) ? 1 : 2 * lo) << hi;
    endfunction

    // Step the rise/fall rule through counts 0..upto starting from level l.
    function automatic logic scan(input logic l, input int rise, input int fall, input int upto);
        logic v;
        v = l;
        for (int k = 0; k <= upto; k++) begin
            if (fall != 0 && fall == k) v = 1'b0;
            else if (rise == k) v = 1'b1;
        end
        return v;
    endfunction

    // Expected level after edge n, edge 0 sampling the enable.
    function automatic logic exp_lvl(input int n, input int d, input int u,
                                     input int rise, input int fall);
        int idx, per, c;
        logic l;
        if (n < 1) return 1'b0;
        idx = (n - 1) / d;
        per = idx / (u + 1);
        c   = idx % (u + 1);
        l   = 1'b0;
        if (per >= 1) l = scan(l, rise, fall, u);
        if (per >= 2) l = scan(l, rise, fall, u);
        return scan(l, rise, fall, c);
    endfunction

    task automatic load_duty();
        for (int p = 0; p < NP; p++) begin
            duty_bus[p*16 +: 8]     = 8'(t_rise[p]);
            duty_bus[p*16 + 8 +: 8] = 8'(t_fall[p]);
        end
    endtask

    task automatic run_trial(input int lo, input int hi, input int u,
                             input logic [NP-1:0] pen, input int ncyc);
        int d;
        d = ratio(lo, hi);
        @(negedge clk);
        ctrl_word = {pen, 1'b0};
        clk_cfg   = {8'(u), 4'(hi), 4'(lo)};
        load_duty();
        @(negedge clk);
        ctrl_word[0] = 1'b1;
        for (int i = 0; i <= ncyc; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                // R3 R4 R5 R6 R7 R8 R9 R11
                chk(pwm_out[p], pen[p] ? exp_lvl(i, d, u, t_rise[p], t_fall[p]) : 1'b0,
                    "R3 R4 R5 R6 R7 R8 R9 R11 waveform");
            end
        end
        ctrl_word[0] = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) chk(pwm_out[p], 1'b0, "R2 global off");
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) chk(pwm_out[p], 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) chk(pwm_out[p], 1'b0, "R1 after reset");

        // Directed: undivided clock, 100%, window, equal points, disabled port
        t_rise[0] = 0; t_fall[0] = 0;
        t_rise[1] = 2; t_fall[1] = 5;
        t_rise[2] = 3; t_fall[2] = 3;
        t_rise[3] = 1; t_fall[3] = 4;
        run_trial(0, 0, 7, 4'b0111, 40);

        // Directed: D=8, rise past unit, fall before rise, 100%
        t_rise[0] = 1; t_fall[0] = 3;
        t_rise[1] = 0; t_fall[1] = 0;
        t_rise[2] = 9; t_fall[2] = 0;
        t_rise[3] = 4; t_fall[3] = 1;
        run_trial(2, 1, 4, 4'b1111, 140);

        // R10: mid-period duty change applies at next boundary (D=1, U=9)
        t_rise[0] = 0; t_fall[0] = 5;
        for (int p = 1; p < NP; p++) begin t_rise[p] = 0; t_fall[p] = 0; end
        @(negedge clk);
        ctrl_word = 5'b00010;
        clk_cfg   = {8'd9, 4'd0, 4'd0};
        load_duty();
        @(negedge clk);
        ctrl_word[0] = 1'b1;
        for (int n = 0; n <= 29; n++) begin
            @(negedge clk);
            if (n == 13) begin
                t_fall[0] = 8;
                load_duty();
            end
            if (n == 16 || n == 18) chk(pwm_out[0], 1'b0, "R10 old fall kept");
            if (n == 26 || n == 27) chk(pwm_out[0], 1'b1, "R10 new fall applied");
            if (n == 29) chk(pwm_out[0], 1'b0, "R10 new fall reached");
        end
        ctrl_word[0] = 1'b0;
        @(negedge clk);
        chk(pwm_out[0], 1'b0, "R2 global off");

        // R9: port enable cleared mid-run
        t_rise[0] = 0; t_fall[0] = 0;
        load_duty();
        @(negedge clk);
        ctrl_word = 5'b00011;
        repeat (4) @(negedge clk);
        chk(pwm_out[0], 1'b1, "R8 full duty");
        ctrl_word[1] = 1'b0;
        @(negedge clk);
        chk(pwm_out[0], 1'b0, "R9 port disabled");
        ctrl_word[0] = 1'b0;
        @(negedge clk);

        // Random trials
        for (int t = 0; t < 20; t++) begin
            int lo, hi, u, d;
            logic [NP-1:0] pen;
            lo  = int'($urandom_range(0, 3));
            hi  = int'($urandom_range(0, 2));
            u   = int'($urandom_range(2, 15));
            pen = NP'($urandom_range(0, (1 << NP) - 1));
            for (int p = 0; p < NP; p++) begin
                t_rise[p] = int'($urandom_range(0, u + 1));
                t_fall[p] = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, u + 1));
            end
            d = ratio(lo, hi);
            run_trial(lo, hi, u, pen, 3 * d * (u + 1) + 4);
        end
        finish_run();
    end

endmodule